// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block takes received frames as a byte stream and stores them in a circular region of packet memory. Each frame is framed by a start pulse, a run of valid data bytes and an end pulse that carries the frame's good/bad verdict. The data is written first, starting six bytes past the frame's base address. Once the frame ends, a six-byte descriptor is written back at the base. The descriptor holds a link to where the next frame will begin, the number of data bytes, and a status word. Stored frames therefore form a chain that the host walks from one link to the next.

The host programs the lower and upper bounds of the ring and a read pointer. Everything from the frame base up to, but not including, the read pointer may be written. The host releases space by moving that pointer forward, and it retires frames with a decrement strobe on a pending-frame counter. A frame that would run into the host's read pointer is dropped as a whole and reported through an error pulse. Frame parsing and CRC checking happen upstream; only their verdict arrives here.

Top module: `rxb_ring_manager`

## Requirements
- R1: After reset the pending count is 0, `mem_we` and `rx_err` are low, the ring spans 0x0000 to 0x17FF, the read pointer is 0x17FF, and the first frame's base is 0x0000.
- R2: The data bytes of a frame go to consecutive ring addresses starting at base+6. Each byte appears on `mem_we`/`mem_addr`/`mem_wdata` one clock after the edge that samples it with `rx_valid`.
- R3: After the edge that samples `rx_end`, the six descriptor bytes are written on the next six clocks at base+0 to base+5. Their order is: next-link low, next-link high, byte-count low, byte-count high, status low, status high.
- R4: The next link is the address that follows the last data byte, wrapped and then rounded up to an even address. The next frame's base is that link.
- R5: Every address advances from the upper bound back to the lower bound, and no write leaves the ring.
- R6: Status bit 7 is 1 exactly when `rx_good` was high at the end and the byte count is at most 1518. All other status bits are 0.
- R7: The pending count rises by one on the clock of the last descriptor byte and falls by one on each `pkt_dec`. When both happen on the same clock it is unchanged. It neither drops below 0 nor goes above 255.
- R8: A data byte that would bring 6 plus the byte count up to the free space is not written. Free space is the circular distance from base to read pointer, taken at frame start. When this happens, `rx_err` pulses for one clock and the rest of the frame is ignored. No descriptor is written, the count is unchanged and the base stays where it was.
- R9: A read-pointer write whose value lies outside the lower..upper range stores the upper bound instead. The selector encoding is: 0 lower bound, 1 upper bound, 2 read pointer, 3 no register.
- R10: Writing the lower bound while no frame is in progress also moves the next frame's base to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | One-cycle pulse that opens a frame |
| rx_valid | input | 1 | Data byte valid |
| rx_data | input | 8 | Frame data byte |
| rx_end | input | 1 | One-cycle pulse that closes a frame |
| rx_good | input | 1 | Upstream verdict, sampled with rx_end |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | Register selector (see R9) |
| cfg_data | input | ADDR_W | Host write value |
| pkt_dec | input | 1 | Host strobe that retires one frame |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | ADDR_W | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write byte |
| pkt_count | output | CNT_W | Frames stored and not yet retired |
| rx_err | output | 1 | One-cycle pulse when a frame is dropped for lack of space |

## Verification
A data byte's memory write is due one clock after its sampling edge. The six descriptor writes fall on the six clocks after the edge that samples the end pulse, and the counter steps on the same edge as the last of them. A drop shows on `rx_err` at the edge that samples the offending byte. The bench drives and samples on falling edges, so each timing check names the exact rising edge it waits for. The end-to-end frame checks wait one clock past the last descriptor write, because the memory model captures each registered write on the following rising edge.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int HDR_BYTES = 6;

    typedef enum logic [1:0] {
        CFG_LO    = 2'd0,
        CFG_HI    = 2'd1,
        CFG_RDPTR = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_DATA,
        WR_HDR
    } wr_state_e;
endpackage

// File: rtl/rxb_bounds.sv
module rxb_bounds
    import rxb_pkg::*;
#(
    parameter int                 ADDR_W = 13,
    parameter logic [ADDR_W-1:0]  RST_LO = '0,
    parameter logic [ADDR_W-1:0]  RST_HI = 13'h17FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi,
    output logic [ADDR_W-1:0] rd_ptr
);
    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] rd;
    } bnd_t;

    bnd_t bnd_d, bnd_q;

    always_comb begin
        bnd_d = bnd_q;
        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_LO:    bnd_d.lo = cfg_data;
                CFG_HI:    bnd_d.hi = cfg_data;
                CFG_RDPTR: bnd_d.rd = (cfg_data < bnd_q.lo || cfg_data > bnd_q.hi)
                                      ? bnd_q.hi : cfg_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd_q.lo <= RST_LO;
            bnd_q.hi <= RST_HI;
            bnd_q.rd <= RST_HI;
        end else begin
            bnd_q <= bnd_d;
        end
    end

    assign lo     = bnd_q.lo;
    assign hi     = bnd_q.hi;
    assign rd_ptr = bnd_q.rd;

    AST_RDPTR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == CFG_RDPTR) |=> (rd_ptr >= lo && rd_ptr <= hi)); // R9
endmodule

// File: rtl/rxb_pkt_counter.sv
module rxb_pkt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        case ({inc, dec})
            2'b10:   if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
            2'b01:   if (cnt_q != '0)      cnt_d = cnt_q - CNT_ONE;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + CNT_ONE || count == $past(count) - CNT_ONE)); // R7
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && dec && !inc) |=> (count == '0)); // R7
endmodule

// File: rtl/rxb_writer.sv
module rxb_writer
    import rxb_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter int                MAX_FRAME = 1518,
    parameter logic [ADDR_W-1:0] RST_BASE  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              rx_good,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic [ADDR_W-1:0] rd_ptr,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_val,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              frame_done,
    output logic              rx_err
);
    localparam int LEN_W = 16;
    localparam int IDX_W = $clog2(HDR_BYTES);
    localparam int HDR_W = 8 * HDR_BYTES;
    localparam logic [ADDR_W-1:0] A_ONE   = ADDR_W'(1);
    localparam logic [ADDR_W:0]   W_ONE   = (ADDR_W+1)'(1);
    localparam logic [ADDR_W:0]   HDR_OFS = (ADDR_W+1)'(HDR_BYTES);
    localparam logic [LEN_W-1:0]  L_ONE   = LEN_W'(1);
    localparam logic [LEN_W-1:0]  L_HDR   = LEN_W'(HDR_BYTES);
    localparam logic [LEN_W-1:0]  L_MAX   = LEN_W'(MAX_FRAME);
    localparam logic [IDX_W-1:0]  IDX_END = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0]  I_ONE   = IDX_W'(1);

    typedef struct packed {
        wr_state_e          st;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  cur;
        logic [ADDR_W-1:0]  hptr;
        logic [ADDR_W-1:0]  nxt;
        logic [ADDR_W:0]    free;
        logic [LEN_W-1:0]   cnt;
        logic               drop;
        logic [HDR_W-1:0]   hdr;
        logic [IDX_W-1:0]   hidx;
        logic               mem_we;
        logic [ADDR_W-1:0]  mem_addr;
        logic [7:0]         mem_wdata;
        logic               err;
    } wr_t;

    wr_t wr_d, wr_q;

    function automatic logic [ADDR_W:0] ring_size(input logic [ADDR_W-1:0] l, input logic [ADDR_W-1:0] h);
        return {1'b0, h} - {1'b0, l} + W_ONE;
    endfunction

    function automatic logic [ADDR_W-1:0] ring_inc(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] l,
                                                   input logic [ADDR_W-1:0] h);
        return (a == h) ? l : a + A_ONE;
    endfunction

    function automatic logic [ADDR_W-1:0] ring_add(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W:0]   k,
                                                   input logic [ADDR_W-1:0] l,
                                                   input logic [ADDR_W-1:0] h);
        logic [ADDR_W:0] s;
        s = {1'b0, a} + k;
        if (s > {1'b0, h}) s = s - ring_size(l, h);
        return s[ADDR_W-1:0];
    endfunction

    function automatic logic [ADDR_W:0] ring_dist(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] b,
                                                  input logic [ADDR_W-1:0] l,
                                                  input logic [ADDR_W-1:0] h);
        if (b >= a) return {1'b0, b} - {1'b0, a};
        return {1'b0, b} + ring_size(l, h) - {1'b0, a};
    endfunction

    logic [ADDR_W-1:0] base_c;
    logic [ADDR_W-1:0] link_c;
    logic [LEN_W-1:0]  need_c;
    logic              ok_c;
    logic [15:0]       status_c;

    always_comb begin
        wr_d           = wr_q;
        wr_d.mem_we    = 1'b0;
        wr_d.err       = 1'b0;
        base_c         = base_load ? base_val : wr_q.base;
        link_c         = wr_q.cur[0] ? ring_inc(wr_q.cur, lo, hi) : wr_q.cur;
        need_c         = L_HDR + wr_q.cnt + L_ONE;
        ok_c           = rx_good && (wr_q.cnt <= L_MAX);
        status_c       = {8'h00, ok_c, 7'h00};
        case (wr_q.st)
            WR_IDLE: begin
                wr_d.base = base_c;
                if (rx_start) begin
                    wr_d.cur  = ring_add(base_c, HDR_OFS, lo, hi);
                    wr_d.free = ring_dist(base_c, rd_ptr, lo, hi);
                    wr_d.cnt  = '0;
                    wr_d.drop = 1'b0;
                    wr_d.st   = WR_DATA;
                end
            end
            WR_DATA: begin
                if (rx_end) begin
                    if (wr_q.drop) begin
                        wr_d.st = WR_IDLE;
                    end else begin
                        wr_d.nxt  = link_c;
                        wr_d.hdr  = {status_c, wr_q.cnt, LEN_W'(link_c)};
                        wr_d.hidx = '0;
                        wr_d.hptr = wr_q.base;
                        wr_d.st   = WR_HDR;
                    end
                end else if (rx_valid && !wr_q.drop) begin
                    if (need_c < LEN_W'(wr_q.free)) begin
                        wr_d.mem_we    = 1'b1;
                        wr_d.mem_addr  = wr_q.cur;
                        wr_d.mem_wdata = rx_data;
                        wr_d.cur       = ring_inc(wr_q.cur, lo, hi);
                        wr_d.cnt       = wr_q.cnt + L_ONE;
                    end else begin
                        wr_d.drop = 1'b1;
                        wr_d.err  = 1'b1;
                    end
                end
            end
            WR_HDR: begin
                wr_d.mem_we    = 1'b1;
                wr_d.mem_addr  = wr_q.hptr;
                wr_d.mem_wdata = wr_q.hdr[8*wr_q.hidx +: 8];
                wr_d.hptr      = ring_inc(wr_q.hptr, lo, hi);
                wr_d.hidx      = wr_q.hidx + I_ONE;
                if (wr_q.hidx == IDX_END) begin
                    wr_d.base = wr_q.nxt;
                    wr_d.st   = WR_IDLE;
                end
            end
            default: wr_d.st = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= '0;
            wr_q.st   <= WR_IDLE;
            wr_q.base <= RST_BASE;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign mem_we     = wr_q.mem_we;
    assign mem_addr   = wr_q.mem_addr;
    assign mem_wdata  = wr_q.mem_wdata;
    assign rx_err     = wr_q.err;
    assign frame_done = (wr_q.st == WR_HDR) && (wr_q.hidx == IDX_END);

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr != rd_ptr)); // R8
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= lo && mem_addr <= hi)); // R5
    AST_BASE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo[0]) |-> (!wr_q.base[0])); // R4
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> !rx_err); // R8
endmodule

// File: rtl/rxb_ring_manager.sv
module rxb_ring_manager
    import rxb_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter int                CNT_W     = 8,
    parameter int                MAX_FRAME = 1518,
    parameter logic [ADDR_W-1:0] RST_LO    = '0,
    parameter logic [ADDR_W-1:0] RST_HI    = 13'h17FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              rx_good,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              pkt_dec,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [CNT_W-1:0]  pkt_count,
    output logic              rx_err
);
    logic [ADDR_W-1:0] lo_w, hi_w, rd_w;
    logic              base_load_w;
    logic              frame_done_w;

    assign base_load_w = cfg_we && (cfg_sel == CFG_LO);

    rxb_bounds #(
        .ADDR_W (ADDR_W),
        .RST_LO (RST_LO),
        .RST_HI (RST_HI)
    ) u_bounds (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .lo       (lo_w),
        .hi       (hi_w),
        .rd_ptr   (rd_w)
    );

    rxb_writer #(
        .ADDR_W    (ADDR_W),
        .MAX_FRAME (MAX_FRAME),
        .RST_BASE  (RST_LO)
    ) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_start   (rx_start),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_end     (rx_end),
        .rx_good    (rx_good),
        .lo         (lo_w),
        .hi         (hi_w),
        .rd_ptr     (rd_w),
        .base_load  (base_load_w),
        .base_val   (cfg_data),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .frame_done (frame_done_w),
        .rx_err     (rx_err)
    );

    rxb_pkt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (frame_done_w),
        .dec   (pkt_dec),
        .count (pkt_count)
    );
endmodule

// File: tb/rxb_ring_manager_bench.sv
`timescale 1ns/1ps
module rxb_ring_manager_bench;
    localparam int ADDR_W = 13;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_good = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = 2'd3;
    logic [ADDR_W-1:0] cfg_data = '0;
    logic              pkt_dec = 1'b0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [CNT_W-1:0]  pkt_count;
    logic              rx_err;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    int err_seen = 0;
    logic [7:0] mem_m [int];

    always #4 clk = ~clk;

    rxb_ring_manager u_rxb_ring_manager (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .rx_good(rx_good), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .pkt_dec(pkt_dec), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pkt_count(pkt_count), .rx_err(rx_err)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                mem_m[int'(mem_addr)] = mem_wdata;
                wr_seen++;
            end
            if (rx_err) err_seen++;
        end
    end

    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  seed;
        logic        good;
        logic        ok;
        logic [15:0] nxt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'd10,  8'h10, 1'b1, 1'b1, 16'h0110},
        '{16'd7,   8'h40, 1'b1, 1'b1, 16'h011E},
        '{16'd20,  8'h60, 1'b0, 1'b0, 16'h0138},
        '{16'd200, 8'h01, 1'b1, 1'b1, 16'h0106},
        '{16'd3,   8'hC0, 1'b1, 1'b1, 16'h0110}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int wrapa(input int a, input int lo, input int hi);
        return lo + ((a - lo) % (hi - lo + 1));
    endfunction

    function automatic logic [7:0] rd_m(input int a);
        if (mem_m.exists(a)) return mem_m[a];
        return 8'hxx;
    endfunction

    task automatic cfg(input logic [1:0] sel, input int val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = ADDR_W'(val);
        step();
        cfg_we = 1'b0; cfg_sel = 2'd3;
        step();
    endtask

    task automatic pulse_dec();
        pkt_dec = 1'b1;
        step();
        pkt_dec = 1'b0;
        step();
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed, input logic good, input logic dec_last);
        rx_start = 1'b1;
        step();
        rx_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = 8'(seed + i);
            step();
        end
        rx_valid = 1'b0;
        rx_end = 1'b1; rx_good = good;
        step();
        rx_end = 1'b0; rx_good = 1'b0;
        repeat (5) step();
        pkt_dec = dec_last;
        step();
        pkt_dec = 1'b0;
        repeat (2) step();
    endtask

    task automatic check_hdr(input int base, input int lo, input int hi, input int nxt,
                             input int len, input logic ok, input string tag);
        check({tag, " R3 R4 link low"},  rd_m(wrapa(base + 0, lo, hi)), nxt & 8'hFF);
        check({tag, " R3 R4 link high"}, rd_m(wrapa(base + 1, lo, hi)), (nxt >> 8) & 8'hFF);
        check({tag, " R3 count low"},    rd_m(wrapa(base + 2, lo, hi)), len & 8'hFF);
        check({tag, " R3 count high"},   rd_m(wrapa(base + 3, lo, hi)), (len >> 8) & 8'hFF);
        check({tag, " R6 status low"},   rd_m(wrapa(base + 4, lo, hi)), ok ? 8'h80 : 8'h00);
        check({tag, " R6 status high"},  rd_m(wrapa(base + 5, lo, hi)), 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base_m;
        int mism;
        int wr0;
        repeat (3) step();
        check("R1 count at reset", pkt_count, 0);
        check("R1 mem_we at reset", mem_we, 0);
        check("R1 rx_err at reset", rx_err, 0);
        rst_n = 1'b1;
        step();

        // R1 R2 R3: default base 0, exact cycle of every write
        rx_start = 1'b1; step(); rx_start = 1'b0;
        rx_valid = 1'b1; rx_data = 8'hA5; step();
        check("R2 first byte we", mem_we, 1);
        check("R1 R2 first byte addr", mem_addr, 6);
        check("R2 first byte data", mem_wdata, 8'hA5);
        rx_data = 8'h3C; step();
        check("R2 second byte addr", mem_addr, 7);
        check("R2 second byte data", mem_wdata, 8'h3C);
        rx_valid = 1'b0; rx_end = 1'b1; rx_good = 1'b1; step();
        rx_end = 1'b0; rx_good = 1'b0;
        check("R3 no write on end edge", mem_we, 0);
        for (int k = 0; k < 6; k++) begin
            logic [7:0] expb;
            step();
            case (k)
                0: expb = 8'h08;
                2: expb = 8'h02;
                4: expb = 8'h80;
                default: expb = 8'h00;
            endcase
            check("R3 header we", mem_we, 1);
            check("R3 header addr", mem_addr, k);
            check("R3 header byte", mem_wdata, expb);
            if (k == 4) check("R7 count before last header byte", pkt_count, 0);
            if (k == 5) check("R7 count with last header byte", pkt_count, 1);
        end
        step();
        cfg(2'd2, 7);
        pulse_dec();
        check("R7 decrement", pkt_count, 0);

        // Table-driven frames in ring 0x100..0x1FF
        cfg(2'd1, 'h1FF);
        cfg(2'd0, 'h100);
        cfg(2'd2, 'h1FF);
        base_m = 'h100;
        foreach (VECS[v]) begin
            send_frame(int'(VECS[v].len), VECS[v].seed, VECS[v].good, 1'b0);
            check_hdr(base_m, 'h100, 'h1FF, int'(VECS[v].nxt), int'(VECS[v].len), VECS[v].ok, "R5 R10 vec");
            mism = 0;
            for (int i = 0; i < int'(VECS[v].len); i++)
                if (rd_m(wrapa(base_m + 6 + i, 'h100, 'h1FF)) !== 8'(VECS[v].seed + i)) mism++;
            check("R2 R5 data bytes mismatched", mism, 0);
            check("R7 count after frame", pkt_count, 1);
            cfg(2'd2, int'(VECS[v].nxt) - 1);
            pulse_dec();
            check("R7 count after retire", pkt_count, 0);
            base_m = int'(VECS[v].nxt);
        end

        // R6: length limit at 1518 / 1519
        cfg(2'd1, 'h17FF);
        cfg(2'd0, 0);
        cfg(2'd2, 'h17FF);
        send_frame(1518, 8'h33, 1'b1, 1'b0);
        check_hdr(0, 0, 'h17FF, 'h5F4, 1518, 1'b1, "R6 max length");
        cfg(2'd2, 'h5F3);
        pulse_dec();
        send_frame(1519, 8'h44, 1'b1, 1'b0);
        check_hdr('h5F4, 0, 'h17FF, 'hBEA, 1519, 1'b0, "R6 over length");
        cfg(2'd2, 'hBE9);
        pulse_dec();

        // R8 R9: clamped read pointer limits free space to 63
        cfg(2'd1, 'h3F);
        cfg(2'd0, 0);
        cfg(2'd2, 'h100);
        for (int a = 0; a < 64; a++) mem_m[a] = 8'hEE;
        wr0 = wr_seen;
        err_seen = 0;
        send_frame(57, 8'h20, 1'b1, 1'b0);
        check("R8 error pulses", err_seen, 1);
        check("R9 clamped pointer: bytes written", wr_seen - wr0, 56);
        check("R8 dropped byte not written", rd_m(62), 8'hEE);
        check("R8 no header for dropped frame", rd_m(0), 8'hEE);
        check("R8 count unchanged on drop", pkt_count, 0);
        send_frame(2, 8'h70, 1'b1, 1'b0);
        check("R8 base unchanged after drop", rd_m(0), 8'h08);
        check("R8 count after next frame", pkt_count, 1);
        cfg(2'd2, 7);
        pulse_dec();

        // R7 saturation with empty frames
        base_m = 8;
        for (int n = 0; n < 258; n++) begin
            int nx;
            send_frame(0, 8'h00, 1'b1, 1'b0);
            nx = wrapa(base_m + 6, 0, 'h3F);
            cfg(2'd2, (nx == 0) ? 'h3F : nx - 1);
            base_m = nx;
        end
        check("R7 saturate at 255", pkt_count, 255);
        repeat (255) pulse_dec();
        check("R7 drained to zero", pkt_count, 0);
        pulse_dec();
        check("R7 no decrement below zero", pkt_count, 0);

        // R7 simultaneous store and retire
        send_frame(0, 8'h00, 1'b1, 1'b0);
        base_m = wrapa(base_m + 6, 0, 'h3F);
        cfg(2'd2, (base_m == 0) ? 'h3F : base_m - 1);
        check("R7 count before overlap", pkt_count, 1);
        send_frame(0, 8'h00, 1'b1, 1'b1);
        check("R7 overlap of store and retire", pkt_count, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule